// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the cartridge side of an 8-bit processor bus with a 16-bit address. It turns bus activity into physical addresses for an external ROM and an external RAM. Neither memory is part of this block. A processor write that lands in the ROM address range does not reach the ROM. The controller takes it as a register write instead. The registers are a RAM enable flag, a 9-bit ROM bank number and a 4-bit RAM bank number.

The lower 16 KB window always shows the first ROM bank. The upper 16 KB window shows whichever bank the register selects, and bank 0 is a legal choice there. The bank number is taken modulo the fitted bank count, which need not be a power of two. The 8 KB RAM window is steered by the RAM bank register and masked to the fitted RAM size. When RAM is disabled or not fitted, RAM accesses are blocked and the bus logic is told to return 0xFF.

The fitted ROM size is set by a parameter of 2 to 512 banks of 16 KB. The fitted RAM size is set by a parameter of 0 (none), 2, 8, 32, 64 or 128 KB.

Top module: `cart_bank_ctrl`

## Requirements
- R1: For addresses 0x0000–0x3FFF, `romAddr` equals the address itself, whatever the bank register holds.
- R2: For addresses 0x4000–0x7FFF, `romAddr` = (bank mod ROM_BANKS) × 16384 + (address − 0x4000).
- R3: A write to 0x0000–0x1FFF sets the RAM enable flag only if the data byte is exactly 0x0A. Any other byte clears it.
- R4: A write to 0x2000–0x2FFF loads bank bits 7:0 from the data byte and leaves bank bit 8 unchanged.
- R5: A write to 0x3000–0x3FFF loads bank bit 8 from data bit 0 and leaves bank bits 7:0 unchanged.
- R6: A write to 0x4000–0x5FFF loads the RAM bank register from data bits 3:0. A write to 0x6000–0x7FFF changes no register.
- R7: After reset, the ROM bank is 1, the RAM bank is 0 and RAM is disabled. Writing bank value 0 selects bank 0, and 0 is not replaced by 1.
- R8: In the window 0xA000–0xBFFF, when RAM is disabled or RAM_KB is 0, `ramSel` and `ramWrEn` are 0 and `rdForceFF` is 1. When RAM is enabled and fitted, `ramSel` is 1, `ramWrEn` follows `cpuWrEn`, and `rdForceFF` is 0.
- R9: `ramAddr` = (RAM bank × 8192 + (address − 0xA000)) masked to RAM_KB × 1024 − 1, so banks beyond the fitted RAM alias onto fitted banks.
- R10: A register write takes effect at the clock edge on which `cpuWrEn` is sampled high. From the next cycle on, the addresses follow the new value with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor address |
| cpuWrData | input | 8 | Processor write data |
| cpuWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| romAddr | output | 23 | Physical ROM byte address |
| ramAddr | output | 17 | Physical RAM byte address |
| ramSel | output | 1 | RAM chip select for an allowed RAM-window access |
| ramWrEn | output | 1 | RAM write enable |
| rdForceFF | output | 1 | Tells the bus logic to return 0xFF for this RAM-window read |

## Verification
The embedded assertions check several properties on every cycle:
- the window decoder raises at most one register strobe at a time;
- a write to 0x6000–0x7FFF raises none;
- each partial bank write keeps the other part of the bank register;
- the enable flag tracks the exact 0x0A value;
- `romAddr` never leaves the fitted ROM;
- the RAM select never asserts while RAM is disabled.

The arithmetic needs the bench's scenarios. These cover the wrap of a non-power-of-two bank count, aliasing of RAM banks beyond the fitted size, bank 0 in the upper window, reset values, the next-cycle visibility of a new bank, and a controller built with no RAM.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  // Register strobes handed from the write decoder to the datapath
  typedef struct packed {
    logic       ramEnWr;
    logic       bankLoWr;
    logic       bankHiWr;
    logic       ramBankWr;
    logic [7:0] data;
  } cbcStrobes_t;

  localparam int ROM_BANK_BITS = 14;  // 16 KB
  localparam int RAM_BANK_BITS = 13;  // 8 KB
  localparam int ROM_SEL_W     = 9;
  localparam int RAM_SEL_W     = 4;
  localparam int ROM_AW        = ROM_BANK_BITS + ROM_SEL_W;
  localparam int RAM_AW        = RAM_BANK_BITS + RAM_SEL_W;

endpackage

// File: rtl/cart_bank_ctrl_dec.sv
module cart_bank_ctrl_dec
  import cart_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  wrAddrHi,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  output cbcStrobes_t strobes
);

  always_comb begin
    strobes      = '0;
    strobes.data = wrData;
    if (wrEn && !wrAddrHi[3]) begin
      unique case (wrAddrHi[2:0])
        3'b000, 3'b001: strobes.ramEnWr   = 1'b1;
        3'b010:         strobes.bankLoWr  = 1'b1;
        3'b011:         strobes.bankHiWr  = 1'b1;
        3'b100, 3'b101: strobes.ramBankWr = 1'b1;
        default:        ;
      endcase
    end
  end

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ramEnWr, strobes.bankLoWr, strobes.bankHiWr, strobes.ramBankWr}));

  // R6
  idle_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddrHi[3:1] == 3'b011) |->
      !(strobes.ramEnWr || strobes.bankLoWr || strobes.bankHiWr || strobes.ramBankWr));

endmodule

// File: rtl/cart_bank_ctrl_dp.sv
module cart_bank_ctrl_dp
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 80,
  parameter int RAM_KB    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbcStrobes_t       strobes,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWrEn,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramSel,
  output logic              ramWrEn,
  output logic              rdForceFF
);

  localparam logic [RAM_AW-1:0] RAM_MASK =
    (RAM_KB == 0) ? '0 : RAM_AW'(RAM_KB * 1024 - 1);
  localparam longint ROM_BYTES = longint'(ROM_BANKS) * (longint'(1) << ROM_BANK_BITS);

  logic [ROM_SEL_W-1:0] romBank;
  logic [RAM_SEL_W-1:0] ramBank;
  logic                 ramEn;
  logic [ROM_SEL_W-1:0] bankWrapped;
  logic [ROM_SEL_W-1:0] winBank;
  logic                 ramWin;
  logic                 ramOk;

  // R7: reset values; R10: update at the write edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romBank <= ROM_SEL_W'(1);
      ramBank <= '0;
      ramEn   <= 1'b0;
    end else begin
      if (strobes.ramEnWr)   ramEn        <= (strobes.data == 8'h0A);
      if (strobes.bankLoWr)  romBank[7:0] <= strobes.data;
      if (strobes.bankHiWr)  romBank[8]   <= strobes.data[0];
      if (strobes.ramBankWr) ramBank      <= strobes.data[RAM_SEL_W-1:0];
    end
  end

  // R2: wrap to the fitted bank count
  assign bankWrapped = ROM_SEL_W'({23'd0, romBank} % 32'(ROM_BANKS));
  // R1: the lower window is always bank 0
  assign winBank     = cpuAddr[14] ? bankWrapped : '0;
  assign romAddr     = {winBank, cpuAddr[ROM_BANK_BITS-1:0]};

  // R9
  assign ramAddr = {ramBank, cpuAddr[RAM_BANK_BITS-1:0]} & RAM_MASK;

  generate
    if (RAM_KB == 0) begin : g_noRam
      assign ramOk = 1'b0;
    end else begin : g_ram
      assign ramOk = ramEn;
    end
  endgenerate

  // R8
  assign ramWin    = (cpuAddr[15:13] == 3'b101);
  assign ramSel    = ramWin && ramOk;
  assign ramWrEn   = ramSel && cpuWrEn;
  assign rdForceFF = ramWin && !ramOk;

  // R3
  ram_enable_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ramEnWr |=> (ramEn == ($past(strobes.data) == 8'h0A)));

  // R4
  bank_hi_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bankLoWr && !strobes.bankHiWr) |=> (romBank[8] == $past(romBank[8])));

  // R5
  bank_lo_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bankHiWr && !strobes.bankLoWr) |=> (romBank[7:0] == $past(romBank[7:0])));

  // R2
  rom_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    longint'(romAddr) < ROM_BYTES);

  // R8
  ram_sel_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> (ramEn && !rdForceFF));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 80,
  parameter int RAM_KB    = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWrEn,
  output logic [22:0] romAddr,
  output logic [16:0] ramAddr,
  output logic        ramSel,
  output logic        ramWrEn,
  output logic        rdForceFF
);

  cbcStrobes_t strobes;

  cart_bank_ctrl_dec dec_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrAddrHi (cpuAddr[15:12]),
    .wrData   (cpuWrData),
    .wrEn     (cpuWrEn),
    .strobes  (strobes)
  );

  cart_bank_ctrl_dp #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_KB    (RAM_KB)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cpuAddr   (cpuAddr),
    .cpuWrEn   (cpuWrEn),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramSel    (ramSel),
    .ramWrEn   (ramWrEn),
    .rdForceFF (rdForceFF)
  );

endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWrEn = 1'b0;
  logic [22:0] romAddr, romAddrN;
  logic [16:0] ramAddr, ramAddrN;
  logic        ramSel, ramWrEn, rdForceFF;
  logic        ramSelN, ramWrEnN, rdForceFFN;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  cart_bank_ctrl #(.ROM_BANKS(80), .RAM_KB(32)) dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .romAddr(romAddr), .ramAddr(ramAddr),
    .ramSel(ramSel), .ramWrEn(ramWrEn), .rdForceFF(rdForceFF));

  cart_bank_ctrl #(.ROM_BANKS(4), .RAM_KB(0)) dutNoRam_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .romAddr(romAddrN), .ramAddr(ramAddrN),
    .ramSel(ramSelN), .ramWrEn(ramWrEnN), .rdForceFF(rdForceFFN));

  // kind: 0 write, 1 check romAddr, 2 check ramAddr ; req ; addr ; data ; expected
  localparam int NV = 24;
  localparam logic [52:0] VECS [NV] = '{
    {2'd1, 4'd1,  16'h1234, 8'h00, 23'h001234},  // R1 lower window
    {2'd1, 4'd7,  16'h4000, 8'h00, 23'h004000},  // R7 reset bank 1
    {2'd0, 4'd7,  16'h2000, 8'h00, 23'h0},
    {2'd1, 4'd7,  16'h4005, 8'h00, 23'h000005},  // R7 bank 0 kept
    {2'd0, 4'd2,  16'h2ABC, 8'h05, 23'h0},
    {2'd1, 4'd2,  16'h7FFF, 8'h00, 23'h017FFF},  // R2 bank 5 top byte
    {2'd1, 4'd1,  16'h3FFF, 8'h00, 23'h003FFF},  // R1 ignores bank
    {2'd0, 4'd5,  16'h3000, 8'h01, 23'h0},
    {2'd1, 4'd10, 16'h4010, 8'h00, 23'h054010},  // R10/R5 bank 261 -> 21
    {2'd0, 4'd4,  16'h2100, 8'h50, 23'h0},
    {2'd1, 4'd4,  16'h4000, 8'h00, 23'h040000},  // R4 bank 336 -> 16
    {2'd0, 4'd5,  16'h3FFF, 8'hFE, 23'h0},
    {2'd1, 4'd5,  16'h4001, 8'h00, 23'h000001},  // R5 bank 80 -> 0
    {2'd0, 4'd6,  16'h6000, 8'h03, 23'h0},
    {2'd1, 4'd6,  16'h4001, 8'h00, 23'h000001},  // R6 no effect
    {2'd0, 4'd2,  16'h2000, 8'h4F, 23'h0},
    {2'd1, 4'd2,  16'h7FFF, 8'h00, 23'h13FFFF},  // R2 last bank
    {2'd0, 4'd3,  16'h0000, 8'h0A, 23'h0},
    {2'd0, 4'd6,  16'h4000, 8'h03, 23'h0},
    {2'd2, 4'd9,  16'hA123, 8'h00, 23'h006123},  // R9 bank 3
    {2'd0, 4'd6,  16'h5FFF, 8'h1D, 23'h0},
    {2'd2, 4'd9,  16'hBFFF, 8'h00, 23'h003FFF},  // R9 bank 13 aliases
    {2'd0, 4'd6,  16'h7000, 8'h00, 23'h0},
    {2'd2, 4'd6,  16'hA000, 8'h00, 23'h002000}   // R6 RAM bank unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic setAddr(input logic [15:0] a);
    cpuAddr = a;
    #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 / R8: RAM disabled after reset
    setAddr(16'hA000);
    check("R7 ramSel after reset", 32'(ramSel), 32'd0);
    check("R8 rdForceFF when disabled", 32'(rdForceFF), 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  kind;
      logic [3:0]  req;
      logic [15:0] a;
      logic [7:0]  d;
      logic [22:0] e;
      {kind, req, a, d, e} = VECS[i];
      if (kind == 2'd0) begin
        busWrite(a, d);
      end else begin
        setAddr(a);
        if (kind == 2'd1) check($sformatf("R%0d romAddr vec %0d", req, i), 32'(romAddr), 32'(e));
        else              check($sformatf("R%0d ramAddr vec %0d", req, i), 32'(ramAddr), 32'(e));
      end
    end

    // R3: exact enable value
    busWrite(16'h1FFF, 8'h0B);
    setAddr(16'hA000);
    check("R3 0x0B disables", 32'(ramSel), 32'd0);
    busWrite(16'h1000, 8'h0A);
    setAddr(16'hA000);
    check("R3 0x0A enables", 32'(ramSel), 32'd1);
    check("R8 no override when enabled", 32'(rdForceFF), 32'd0);
    busWrite(16'h0000, 8'h8A);
    setAddr(16'hA000);
    check("R3 0x8A disables", 32'(ramSel), 32'd0);

    // R8: write gating
    busWrite(16'h0000, 8'h0A);
    @(negedge clk);
    cpuAddr = 16'hB000; cpuWrEn = 1'b1; #1;
    check("R8 ramWrEn when enabled", 32'(ramWrEn), 32'd1);
    check("R8 no-RAM build blocks write", 32'(ramWrEnN), 32'd0);
    check("R8 no-RAM build forces FF", 32'(rdForceFFN), 32'd1);
    @(negedge clk);
    cpuWrEn = 1'b0;
    busWrite(16'h0100, 8'h00);
    @(negedge clk);
    cpuAddr = 16'hB000; cpuWrEn = 1'b1; #1;
    check("R8 ramWrEn when disabled", 32'(ramWrEn), 32'd0);
    @(negedge clk);
    cpuWrEn = 1'b0;

    // R10: new bank visible the cycle after the write
    busWrite(16'h2000, 8'h07);
    setAddr(16'h4000);
    check("R10 next-cycle bank", 32'(romAddr), 32'h01C000);
    // R2: no-RAM build, 4 banks: bank 7 wraps to 3
    check("R2 wrap on 4-bank build", 32'(romAddrN), 32'h00C000);

    // R7: reset returns bank 1
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    setAddr(16'h4000);
    check("R7 bank after second reset", 32'(romAddr), 32'h004000);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule